// File: doc/BRIEF.md
# Partially Parallel Sum Reduction

This block adds up a group of M unsigned integers that arrive P at a time, so one group occupies M/P consecutive enabled cycles. On each enabled cycle the P lanes are added in a combinational tree. The lane total is folded into a registered running sum. On the last beat of a group, the output presents the full group sum. That sum includes the lanes on the input in that same cycle, so the result is visible before the closing clock edge.

The block never stalls its source, and a new group may begin on the cycle right after a result. A clock enable freezes the beat count and the running sum. With P equal to 1 the block behaves as a plain serial accumulator over M beats. All arithmetic is W bits wide and wraps.

Top module: `sum_reduce_pp`

## Requirements
- R1: `ready_o` is high on every cycle, in reset and out of it.
- R2: `valid_o` is high exactly while the number of enabled beats already taken in the current group equals M/P-1. It is low on the group's earlier beats. When M equals P it is high on every cycle.
- R3: While `valid_o` is high, `sum_o` equals the sum of every operand of the group. This includes the P lanes currently on `lanes_i`.
- R4: All sums wrap modulo 2^W, and no carry-out exists. For example, three lanes of 2047 at W=11 give a lane total of 2045.
- R5: An enabled edge taken while `valid_o` is high clears the running sum and the beat count. The next cycle therefore begins a fresh group, with no idle cycle between groups.
- R6: While `en` is low, the edge changes neither the beat count nor the running sum. `valid_o` keeps its value, and `sum_o` still shows the held running sum plus the current lanes.
- R7: Reset (`rst_n` low, asynchronous) clears the beat count and the running sum. The first cycle after reset therefore shows `sum_o` equal to the current lane total.
- R8: On a beat that is not the last, `sum_o` equals the running sum of the group's earlier beats plus the current lanes. After an enabled edge, the running sum takes that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable for the beat count and running sum |
| lanes_i | input | P*W (P x W packed) | The P operands of the current beat; lane k occupies bits k*W+W-1 down to k*W |
| sum_o | output | W | Running sum plus the current lane total; the group sum when `valid_o` is high |
| ready_o | output | 1 | Always high: the input is accepted every cycle |
| valid_o | output | 1 | High on the final beat of a group |

## Verification
The bench builds two instances side by side. The first uses W=11, M=12 and P=3, which exercises a three-lane tree padded to four leaves and four-beat groups. The 11-bit width allows all-ones lanes to overflow on every beat. The second uses W=8, M=13 and P=1, which collapses the tree to a wire and gives a thirteen-beat serial group whose count is not a power of two. Driving the two instances with independent random enables reaches stalls on the first beat, on a middle beat and on the final beat of a group, as well as back-to-back groups.

// File: rtl/sum_reduce_pkg.sv
package sum_reduce_pkg;

    // Counter width that stays legal when the count has a single state.
    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of levels in a binary tree that covers n leaves.
    function automatic int tree_levels(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/srp_lane_tree.sv
module srp_lane_tree #(
    parameter int W = 11,
    parameter int P = 3
) (
    input  logic [P-1:0][W-1:0] lanes_i,
    output logic [W-1:0]        total_o
);
    import sum_reduce_pkg::*;

    localparam int LV = tree_levels(P);
    localparam int NP = 1 << LV;

    for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
        localparam int NODES = NP >> lv;
        logic [W-1:0] v [NODES];
        if (lv == 0) begin : g_leaf
            for (genvar j = 0; j < NODES; j++) begin : g_in
                if (j < P) begin : g_used
                    assign v[j] = lanes_i[j];
                end else begin : g_pad
                    assign v[j] = '0;
                end
            end
        end else begin : g_add
            for (genvar j = 0; j < NODES; j++) begin : g_pair
                assign v[j] = g_lvl[lv-1].v[2*j] + g_lvl[lv-1].v[2*j+1];
            end
        end
    end

    assign total_o = g_lvl[LV].v[0];

endmodule

// File: rtl/srp_beat_counter.sv
module srp_beat_counter #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic last_o
);
    import sum_reduce_pkg::*;

    localparam int             CW   = cnt_bits(CYC);
    localparam logic [CW-1:0]  LAST = CW'(CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } beat_state_t;

    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.cnt == LAST);

    // R2: the beat count never leaves its group range
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R6: a disabled edge leaves the beat count untouched
    p_hold_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.cnt));

    if (CYC > 1) begin : g_gap
        // R5: an enabled final beat is followed by a first beat
        p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en && last_o) |=> (!last_o && st_q.cnt == '0));
    end

endmodule

// File: rtl/srp_accum.sv
module srp_accum #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         grp_end_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] acc_o
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (grp_end_i) begin
                st_d.acc = '0;
            end else begin
                st_d.acc = st_q.acc + add_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

    // R5: the running sum is empty after an enabled group end
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && grp_end_i) |=> (st_q.acc == '0));

    // R6: a disabled edge leaves the running sum untouched
    p_hold_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.acc));

endmodule

// File: rtl/sum_reduce_pp.sv
module sum_reduce_pp #(
    parameter int W = 11,
    parameter int M = 12,
    parameter int P = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [P-1:0][W-1:0] lanes_i,
    output logic [W-1:0]       sum_o,
    output logic               ready_o,
    output logic               valid_o
);
    localparam int CYC = M / P;

    logic [W-1:0] lane_total;
    logic [W-1:0] acc;
    logic         grp_end;

    srp_lane_tree #(.W(W), .P(P)) u_tree (
        .lanes_i (lanes_i),
        .total_o (lane_total)
    );

    srp_beat_counter #(.CYC(CYC)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .last_o (grp_end)
    );

    srp_accum #(.W(W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .grp_end_i (grp_end),
        .add_i     (lane_total),
        .acc_o     (acc)
    );

    assign sum_o   = acc + lane_total;
    assign valid_o = grp_end;
    assign ready_o = 1'b1;

    // R8: a non-final enabled beat hands its output sum to the running sum
    p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !valid_o) |=> (acc == $past(sum_o)));

    // R6: a disabled edge keeps the result flag
    p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (valid_o == $past(valid_o)));

endmodule

// File: tb/sim_sum_reduce_pp.sv
`timescale 1ns/1ps
module sim_sum_reduce_pp;

    localparam int W0 = 11, M0 = 12, P0 = 3, C0 = M0 / P0;
    localparam int W1 = 8,  M1 = 13, P1 = 1, C1 = M1 / P1;
    localparam int MASK0 = (1 << W0) - 1;
    localparam int MASK1 = (1 << W1) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en0 = 1'b0, en1 = 1'b0;
    logic [P0-1:0][W0-1:0] a0 = '0;
    logic [P1-1:0][W1-1:0] a1 = '0;
    logic [W0-1:0] s0;
    logic [W1-1:0] s1;
    logic r0, v0, r1, v1;

    always #5 clk = ~clk;

    sum_reduce_pp #(.W(W0), .M(M0), .P(P0)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en0), .lanes_i(a0),
        .sum_o(s0), .ready_o(r0), .valid_o(v0)
    );

    sum_reduce_pp #(.W(W1), .M(M1), .P(P1)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en1), .lanes_i(a1),
        .sum_o(s1), .ready_o(r1), .valid_o(v1)
    );

    int checks = 0;
    int errors = 0;
    int cnt0 = 0, acc0 = 0, cnt1 = 0, acc1 = 0;
    bit first = 1'b0, wrap_phase = 1'b0;
    bit stall0 = 1'b0, stall1 = 1'b0, fresh0 = 1'b0, fresh1 = 1'b0;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int total0(input logic [P0-1:0][W0-1:0] x);
        int t = 0;
        for (int k = 0; k < P0; k++) t += int'(x[k]);
        return t & MASK0;
    endfunction

    function automatic string sum_tag(input bit last, input bit stalled, input bit fresh);
        if (first)      return "R7";
        if (wrap_phase) return "R4";
        if (last)       return "R3";
        if (stalled)    return "R6";
        if (fresh)      return "R5";
        return "R8";
    endfunction

    // Called shortly after a falling edge with inputs already driven.
    task automatic evaluate();
        int t0, t1;
        bit l0, l1;
        #1;
        t0 = total0(a0);
        t1 = int'(a1[0]) & MASK1;
        l0 = (cnt0 == C0 - 1);
        l1 = (cnt1 == C1 - 1);
        check("R1", int'(r0), 1);
        check("R1", int'(r1), 1);
        check(first ? "R7" : "R2", int'(v0), int'(l0));
        check(first ? "R7" : "R2", int'(v1), int'(l1));
        check(sum_tag(l0, stall0, fresh0), int'(s0), (acc0 + t0) & MASK0);
        check(sum_tag(l1, stall1, fresh1), int'(s1), (acc1 + t1) & MASK1);
        first = 1'b0;
        stall0 = !en0;
        stall1 = !en1;
        fresh0 = en0 && l0;
        fresh1 = en1 && l1;
        if (en0) begin
            if (l0) begin cnt0 = 0; acc0 = 0; end
            else begin cnt0++; acc0 = (acc0 + t0) & MASK0; end
        end
        if (en1) begin
            if (l1) begin cnt1 = 0; acc1 = 0; end
            else begin cnt1++; acc1 = (acc1 + t1) & MASK1; end
        end
    endtask

    task automatic drive(input bit e0, input bit e1, input bit maxed);
        @(negedge clk);
        en0 = e0;
        en1 = e1;
        for (int k = 0; k < P0; k++) a0[k] = maxed ? W0'(MASK0) : W0'($urandom);
        a1[0] = maxed ? W1'(MASK1) : W1'($urandom);
        evaluate();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: ready during reset
        check("R1", int'(r0), 1);
        check("R1", int'(r1), 1);
        rst_n = 1'b1;
        first = 1'b1;
        // R7: first cycle after reset, with enable low (also R6)
        drive(1'b0, 1'b0, 1'b0);
        // R4: all-ones lanes for full groups in both instances
        wrap_phase = 1'b1;
        for (int i = 0; i < 2 * C1; i++) drive(1'b1, 1'b1, 1'b1);
        wrap_phase = 1'b0;
        // R3/R5: back-to-back groups with enable always high
        for (int i = 0; i < 3 * C1; i++) drive(1'b1, 1'b1, 1'b0);
        // R6: a long stall
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, 1'b0);
        // R2/R6/R8: random enables
        for (int i = 0; i < 800; i++)
            drive(($urandom % 4) != 0, ($urandom % 3) != 0, 1'b0);
        // R6: stall exactly on a final beat, then release
        while (cnt0 != C0 - 1) drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 2 * C1; i++) drive(1'b1, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule